// File: doc/BRIEF.md
# Peripheral Port B with Write-Strobe Handshake

This block is one side of a parallel peripheral adapter. A CPU reaches three registers through two addresses: a direction register and an output register share one address, and a control register sits at the other. Each pin of the port is either driven from the output register or read back from the outside, depending on its direction bit. Two handshake lines work alongside the data pins. The first, `hs1_in`, is always an input. The second, `hs2`, is an input or an output depending on the control register.

When `hs2` is an output in strobe mode, a CPU write to the output register pulls it low. It returns high in one of two ways. In cycle-restore mode it comes back after one clock. In edge-restore mode it comes back on the next active `hs1_in` transition. A data read that finds the `hs1` flag set also returns it high. Both handshake lines can raise an interrupt flag on a selectable edge. A data read clears both flags.

Top module: `pia_b_port`

## Requirements
- R1: After a clocked reset, the direction, output and control registers are zero, `irq` is low, `hs2_oe` is low and `pin_dir` is zero.
- R2: Control bit 2 picks the target at address 0: 0 selects the direction register, 1 selects the output register. A read of the output register returns `(out & dir) | (pin_in & ~dir)`. `pin_out` carries the output register and `pin_dir` carries the direction register.
- R3: Control bit 1 picks the `hs1_in` active edge: 1 for rising, 0 for falling. Only an active transition sets flag 1. A control read shows flag 1 in bit 7 and control bits 5..0 in bits 5..0.
- R4: A read at address 0 while bit 2 is 1 clears both flags. A direction-register read clears neither flag.
- R5: `irq` = (flag1 & bit0) | (flag2 & bit3 & ~bit5).
- R6: While bit 5 is 0, `hs2` is an input. Its active edge is picked by bit 4 (1 = rising) and sets flag 2. Control-read bit 6 shows flag 2 only while bit 5 is 0.
- R7: While bits 5:4 = 10 (strobe mode), a write to the output register drives `hs2_out` low on the next cycle. With bit 3 = 1, it returns high one cycle later. A direction-register write has no effect on `hs2_out`.
- R8: In strobe mode with bit 3 = 0, `hs2_out` stays low until the next active `hs1_in` transition, then goes high.
- R9: In strobe mode with bit 3 = 0, a data read that finds flag 1 set drives `hs2_out` high. With flag 1 clear, the read leaves it low.
- R10: While bits 5:4 = 11, `hs2_out` equals bit 3. `hs2_oe` equals bit 5.
- R11: If an active edge and a clearing data read fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = direction/output, 1 = control |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data (combinational) |
| pin_in | input | DW | Sampled port pins |
| pin_out | output | DW | Output register to the pads |
| pin_dir | output | DW | Direction register (1 = drive) |
| hs1_in | input | 1 | Edge-detect handshake input |
| hs2_in | input | 1 | Second handshake line, input path |
| hs2_out | output | 1 | Second handshake line, output value |
| hs2_oe | output | 1 | Second handshake line drive enable |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with the default data width of 8. At that width every control field and both flag bits sit in one read word, so the checks can cover the flag bits, both edge polarities and all four `hs2` modes. They also cover the mixed read-back of pins driven and undriven. The scoreboard cases focus on orderings: a strobe started by a write, then released by a timed return, an edge or a flag-clearing read, and an edge that lands in the same cycle as a read.

// File: rtl/pia_b_pkg.sv
// Shared definitions for the port-B adapter: control-bit positions and the
// decoded mode of the second handshake line.
package pia_b_pkg;
    localparam int CTL_W      = 6;
    localparam int B_IRQ1_EN  = 0;
    localparam int B_EDGE1    = 1;
    localparam int B_SEL_OUT  = 2;
    localparam int B_HS2_LO   = 3;
    localparam int B_HS2_MID  = 4;
    localparam int B_HS2_DIR  = 5;

    typedef enum logic [1:0] {
        HS2_INPUT  = 2'd0,
        HS2_STROBE = 2'd1,
        HS2_LEVEL  = 2'd2
    } hs2_mode_e;

    // Map the control bits onto the handshake line mode.
    function automatic hs2_mode_e hs2_mode(input logic [CTL_W-1:0] c);
        if (!c[B_HS2_DIR])      return HS2_INPUT;
        else if (c[B_HS2_MID])  return HS2_LEVEL;
        else                    return HS2_STROBE;
    endfunction
endpackage

// File: rtl/pia_b_edge.sv
// Edge detector for a handshake input. Assumes the pin is already
// synchronous to clk. The previous sample follows the pin during reset
// too, so a static level at reset release is not seen as an edge.
module pia_b_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic active
);
    logic prev_q;

    // Remember the pin level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= pin;
        else        prev_q <= pin;
    end

    // An active edge is a change toward the selected level.
    always_comb active = (pin ^ prev_q) & (pin == rise_sel);
endmodule

// File: rtl/pia_b_hs.sv
// Output side of the second handshake line. Holds the strobe level and
// chooses between the strobe level and the manual control bit.
// Assumes a write and a restore event in the same cycle resolve to low.
module pia_b_hs
    import pia_b_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTL_W-1:0] ctl,
    input  logic             out_wr,
    input  logic             edge1,
    input  logic             rd_restore,
    output logic             hs_out,
    output logic             hs_oe
);
    hs2_mode_e mode;
    logic      lvl_q;
    logic      cyc_restore;

    // Decode the mode and the restore variant.
    always_comb begin
        mode        = hs2_mode(ctl);
        cyc_restore = ctl[B_HS2_LO];
    end

    // Strobe level: low on an output write, high again on the chosen event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b1;
        end else if (mode != HS2_STROBE) begin
            lvl_q <= 1'b1;
        end else if (out_wr) begin
            lvl_q <= 1'b0;
        end else if (cyc_restore && !lvl_q) begin
            lvl_q <= 1'b1;
        end else if (!cyc_restore && (edge1 || rd_restore)) begin
            lvl_q <= 1'b1;
        end
    end

    // Choose the driven value and the enable.
    always_comb begin
        hs_out = (mode == HS2_LEVEL) ? ctl[B_HS2_LO] : lvl_q;
        hs_oe  = ctl[B_HS2_DIR];
    end
endmodule

// File: rtl/pia_b_port.sv
// Port-B side of a parallel adapter: direction/output/control registers,
// two edge-flagged handshake inputs, one strobe-capable handshake output,
// and an interrupt. Read data is combinational and its side effects
// take place on the clock edge of the read cycle.
module pia_b_port
    import pia_b_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] pin_in,
    output logic [DW-1:0] pin_out,
    output logic [DW-1:0] pin_dir,
    input  logic          hs1_in,
    input  logic          hs2_in,
    output logic          hs2_out,
    output logic          hs2_oe,
    output logic          irq
);
    localparam int NEDGE = 2;

    logic [DW-1:0]    dir_q, out_q;
    logic [CTL_W-1:0] ctl_q;
    logic             flag1_q, flag2_q;
    logic [NEDGE-1:0] edge_pin, edge_pol, edge_act;
    logic             wr_data, wr_dir, wr_ctl, rd_data;
    logic             hs2_is_in, strobe_c1;

    // Decode the bus access of this cycle.
    always_comb begin
        wr_data   = bus_sel && bus_wr && !bus_addr && ctl_q[B_SEL_OUT];
        wr_dir    = bus_sel && bus_wr && !bus_addr && !ctl_q[B_SEL_OUT];
        wr_ctl    = bus_sel && bus_wr && bus_addr;
        rd_data   = bus_sel && !bus_wr && !bus_addr && ctl_q[B_SEL_OUT];
        hs2_is_in = !ctl_q[B_HS2_DIR];
        strobe_c1 = (hs2_mode(ctl_q) == HS2_STROBE) && !ctl_q[B_HS2_LO];
        edge_pin  = {hs2_in, hs1_in};
        edge_pol  = {ctl_q[B_HS2_MID], ctl_q[B_EDGE1]};
    end

    // One edge detector per handshake input.
    for (genvar g = 0; g < NEDGE; g++) begin : g_edge
        pia_b_edge u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (edge_pin[g]),
            .rise_sel(edge_pol[g]),
            .active  (edge_act[g])
        );
    end

    // CPU-writable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
            ctl_q <= '0;
        end else begin
            if (wr_dir)  dir_q <= bus_wdata;
            if (wr_data) out_q <= bus_wdata;
            if (wr_ctl)  ctl_q <= bus_wdata[CTL_W-1:0];
        end
    end

    // Interrupt flags: a new edge wins over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag1_q <= 1'b0;
            flag2_q <= 1'b0;
        end else begin
            if (edge_act[0])               flag1_q <= 1'b1;
            else if (rd_data)              flag1_q <= 1'b0;
            if (edge_act[1] && hs2_is_in)  flag2_q <= 1'b1;
            else if (rd_data)              flag2_q <= 1'b0;
        end
    end

    pia_b_hs u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl_q),
        .out_wr    (wr_data),
        .edge1     (edge_act[0]),
        .rd_restore(rd_data && flag1_q && strobe_c1),
        .hs_out    (hs2_out),
        .hs_oe     (hs2_oe)
    );

    // Read mux and outputs.
    always_comb begin
        if (bus_addr)
            bus_rdata = DW'({flag1_q, flag2_q & hs2_is_in, ctl_q});
        else if (ctl_q[B_SEL_OUT])
            bus_rdata = (out_q & dir_q) | (pin_in & ~dir_q);
        else
            bus_rdata = dir_q;
        pin_out = out_q;
        pin_dir = dir_q;
        irq     = (flag1_q & ctl_q[B_IRQ1_EN])
                | (flag2_q & ctl_q[B_HS2_LO] & hs2_is_in);
    end
endmodule

// File: rtl/pia_b_port_chk.sv
// Temporal checks on the port-B adapter, bound into every instance.
module pia_b_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] ctl,
    input logic       wr_data,
    input logic       wr_ctl,
    input logic       rd_data,
    input logic       flag1,
    input logic [1:0] edge_act,
    input logic       hs2_out,
    input logic       hs2_oe,
    input logic       irq
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq && !hs2_oe)); // R1

    AST_EDGE1_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_act[0] && ctl[0] && !wr_ctl) |=> irq); // R3

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && edge_act == 2'b00) |=> !irq); // R4

    AST_WRITE_STROBE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && ctl[5:4] == 2'b10) |=> !hs2_out); // R7

    AST_CYCLE_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[5:3] == 3'b101 && !hs2_out && !wr_data && !wr_ctl) |=> hs2_out); // R7

    AST_READ_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && flag1 && ctl[5:3] == 3'b100) |=> hs2_out); // R9
endmodule

bind pia_b_port pia_b_port_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl_q),
    .wr_data (wr_data),
    .wr_ctl  (wr_ctl),
    .rd_data (rd_data),
    .flag1   (flag1_q),
    .edge_act(edge_act),
    .hs2_out (hs2_out),
    .hs2_oe  (hs2_oe),
    .irq     (irq)
);

// File: tb/pia_b_port_tb.sv
module pia_b_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata, pin_in = 8'hA5, pin_out, pin_dir;
    logic       hs1_in = 1'b0, hs2_in = 1'b0, hs2_out, hs2_oe, irq;

    always #4 clk = ~clk;

    pia_b_port #(.DW(8)) u_dut (.*);

    typedef struct {
        int         kind;   // 0 rdata 1 irq 2 hs2_out 3 hs2_oe 4 pin_out 5 pin_dir
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t q[$];
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Driver helpers: every call starts on a falling edge.
    task automatic push(int kind, logic [7:0] exp, string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask
    task automatic idle();
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
    endtask
    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask
    task automatic rd(logic a, logic [7:0] exp, string req);
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        push(0, exp, req);
    endtask
    task automatic set1(logic v);
        idle(); hs1_in = v;
    endtask
    task automatic set2(logic v);
        idle(); hs2_in = v;
    endtask

    // Monitor: compare queued expectations shortly after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = q.pop_front();
                case (it.kind)
                    0: act = bus_rdata;
                    1: act = {7'd0, irq};
                    2: act = {7'd0, hs2_out};
                    3: act = {7'd0, hs2_oe};
                    4: act = pin_out;
                    default: act = pin_dir;
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        idle(); push(1, 0, "R1"); push(3, 0, "R1"); push(5, 0, "R1");
        rd(0, 8'h00, "R1");
        rd(1, 8'h00, "R1");
        // R2 shared address and mixed read
        wr(0, 8'hF0);
        wr(1, 8'h04);
        wr(0, 8'h3C);
        rd(0, 8'h35, "R2");
        idle(); push(4, 8'h3C, "R2"); push(5, 8'hF0, "R2");
        wr(1, 8'h00);
        rd(0, 8'hF0, "R2");
        // R3 falling edge selected, rising ignored
        wr(1, 8'h05);
        set1(1'b1); idle();
        rd(1, 8'h05, "R3");
        set1(1'b0); idle(); push(1, 1, "R5");
        rd(1, 8'h85, "R3");
        // R4 data read clears; direction read does not
        rd(0, 8'h35, "R4");
        idle(); push(1, 0, "R4");
        rd(1, 8'h05, "R4");
        set1(1'b1); set1(1'b0); idle();
        wr(1, 8'h01);
        rd(0, 8'hF0, "R4");
        idle(); push(1, 1, "R4");
        rd(1, 8'h81, "R4");
        wr(1, 8'h05);
        rd(0, 8'h35, "R4");
        // R5 enable gating
        wr(1, 8'h04);
        set1(1'b1); set1(1'b0); idle(); push(1, 0, "R5");
        rd(1, 8'h84, "R5");
        wr(1, 8'h05);
        idle(); push(1, 1, "R5");
        rd(0, 8'h35, "R5");
        // R3 rising edge selected
        wr(1, 8'h07);
        set1(1'b1); idle();
        rd(1, 8'h87, "R3");
        rd(0, 8'h35, "R3");
        // R6 handshake-2 input edge
        wr(1, 8'h1C);
        set2(1'b1); idle(); push(1, 1, "R6");
        rd(1, 8'h5C, "R6");
        // R10 manual level, R6 flag hidden in output mode
        wr(1, 8'h3C);
        idle(); push(1, 0, "R6"); push(2, 1, "R10"); push(3, 1, "R10");
        rd(1, 8'h3C, "R6");
        wr(1, 8'h34);
        idle(); push(2, 0, "R10");
        rd(0, 8'h35, "R4");
        wr(1, 8'h1C);
        set2(1'b0); idle();
        rd(1, 8'h1C, "R6");
        // R7 write strobe with one-cycle return
        wr(1, 8'h2C);
        idle(); push(2, 1, "R7"); push(3, 1, "R7");
        wr(0, 8'h11);
        idle(); push(2, 0, "R7");
        idle(); push(2, 1, "R7");
        wr(1, 8'h28);
        wr(0, 8'hF0);
        idle(); push(2, 1, "R7");
        // R8 edge-restored strobe (falling edge, hs1 now high)
        wr(1, 8'h24);
        rd(0, 8'h15, "R2");
        wr(0, 8'h22);
        idle(); push(2, 0, "R8");
        idle(); push(2, 0, "R8");
        set1(1'b0); idle(); push(2, 1, "R8");
        rd(1, 8'hA4, "R8");
        // R9 read restores while flag 1 is set
        wr(0, 8'h33);
        idle(); push(2, 0, "R9");
        rd(0, 8'h35, "R9");
        idle(); push(2, 1, "R9");
        rd(1, 8'h24, "R9");
        wr(0, 8'h44);
        rd(0, 8'h45, "R9");
        idle(); push(2, 0, "R9");
        // R11 edge and clearing read in the same cycle
        wr(1, 8'h05);
        set1(1'b1); idle();
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 1'b0; hs1_in = 1'b0;
        push(0, 8'h45, "R11");
        idle(); push(1, 1, "R11");
        rd(1, 8'h85, "R11");
        idle(); idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule